// File: doc/BRIEF.md
# Floating-Point to Signed Integer Converter

This block turns an unpacked floating-point operand into a signed two's-complement integer of `INT_W` bits (32 or 64). The operand arrives as a class code, a sign, an unbiased exponent and a normalised mantissa with the leading one at its top bit. The conversion always truncates toward zero, whatever rounding mode the surrounding unit uses. Any fraction bits that are dropped raise an inexact flag.

The mantissa is shifted right so that its integer part lands in the low `INT_W` bits. Every bit that leaves the word is collected into a sticky bit. Operands that cannot be represented are saturated and raise an invalid-conversion flag, which takes the place of inexact. These are exponents at or above the integer width, magnitudes past the sign-dependent limit, infinities and NaNs. The datapath has two register stages. One operand can be accepted on every clock, and `in_valid` is carried alongside the data.

Top module: `f2i_convert`

## Requirements
- R1: An operand with class code 0 (zero) yields `out_int` = 0 with `out_inexact` and `out_invalid` both low, whatever its sign, exponent or mantissa.
- R2: A class-1 (normal) operand has the value `in_mant` × 2^(`in_exp` − (MANT_W−1)), where `in_exp` is two's complement and `in_mant[MANT_W-1]` is set. Its result is that value truncated toward zero. `out_inexact` is high exactly when nonzero fraction bits were dropped and no overflow occurred.
- R3: A normal operand with a negative exponent produces 0 and raises `out_inexact`.
- R4: A normal operand with `in_exp` ≥ INT_W overflows.
- R5: A truncated magnitude M overflows when M ≥ 2^(INT_W−1) + sign. This makes −2^(INT_W−1) representable and +2^(INT_W−1) an overflow.
- R6: Class codes 2 (infinity), 3 (quiet NaN) and 4 (signalling NaN) always take the overflow path. No other class code is legal.
- R7: On overflow `out_invalid` is 1 and `out_inexact` is 0. `out_int` is 2^(INT_W−1)−1 for a positive sign and −2^(INT_W−1) for a negative sign.
- R8: A non-overflowing result with the sign set is the two's-complement negation of the truncated magnitude.
- R9: The result for an operand presented with `in_valid` appears two clocks later with `out_valid` high. While reset is asserted, `out_valid`, `out_int` and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand present this cycle |
| in_class | input | 3 | Class code: 0 zero, 1 normal, 2 infinity, 3 quiet NaN, 4 signalling NaN |
| in_sign | input | 1 | Sign, 1 = negative |
| in_exp | input | EXP_W | Unbiased exponent, two's complement |
| in_mant | input | MANT_W | Mantissa with the leading one at the top bit |
| out_valid | output | 1 | Result present this cycle |
| out_int | output | INT_W | Signed integer result |
| out_inexact | output | 1 | Fraction bits were dropped |
| out_invalid | output | 1 | Operand not representable; result saturated |

## Verification
The assertions assume three things about every valid operand. Its class code is one of the five legal values. A normal operand carries a mantissa with its top bit set. Its exponent is small enough that the shift-amount arithmetic cannot wrap. The stimulus respects all three. It draws class codes only from the legal set and builds every normal mantissa with the leading one forced. It keeps random exponents a few steps either side of the range from 0 to INT_W. Directed operands sit on the saturation boundary at ±2^(INT_W−1) and ±(2^(INT_W−1)−1), just above and below those values, and deep into negative and large exponents.

// File: rtl/f2i_pkg.sv
package f2i_pkg;

   typedef enum logic [2:0] {
      CLS_ZERO = 3'd0,
      CLS_NORM = 3'd1,
      CLS_INF  = 3'd2,
      CLS_QNAN = 3'd3,
      CLS_SNAN = 3'd4
   } f2i_class_e;

   // Non-numbers and infinities share the saturating path.
   function automatic logic f2i_is_special(input logic [2:0] cls);
      return (cls == CLS_INF) || (cls == CLS_QNAN) || (cls == CLS_SNAN);
   endfunction

endpackage

// File: rtl/f2i_align.sv
// Right-aligns the integer part of the mantissa into the low INT_W bits and
// gathers every bit shifted out into a sticky flag.
module f2i_align #(
   parameter int INT_W  = 32,
   parameter int MANT_W = 53,
   parameter int EXP_W  = 12
) (
   input  logic [MANT_W-1:0]       mant,
   input  logic signed [EXP_W-1:0] exp_i,
   output logic [INT_W-1:0]        mag,
   output logic                    sticky,
   output logic                    exp_big
);
   localparam int WW   = MANT_W + INT_W;
   localparam int SHW  = $clog2(WW);
   localparam int AW   = EXP_W + 2;
   localparam int BASE = MANT_W - 1 + INT_W;

   localparam logic signed [AW-1:0] BASE_S = AW'(BASE);
   localparam logic signed [AW-1:0] WW_S   = AW'(WW);
   localparam logic signed [AW-1:0] INTW_S = AW'(INT_W);

   logic signed [AW-1:0] exp_ext;
   logic signed [AW-1:0] amt_full;
   logic                 clamp;
   logic                 under;
   logic [SHW-1:0]       amt;

   assign exp_ext  = {{2{exp_i[EXP_W-1]}}, exp_i};
   assign amt_full = BASE_S - exp_ext;
   assign clamp    = (amt_full >= WW_S);
   assign under    = (amt_full < 0);
   assign amt      = (clamp || under) ? '0 : amt_full[SHW-1:0];
   assign exp_big  = (exp_ext >= INTW_S);

   logic [WW-1:0] stage_v [0:SHW];
   logic          stage_s [0:SHW];

   assign stage_v[0] = {mant, {INT_W{1'b0}}};
   assign stage_s[0] = 1'b0;

   for (genvar k = 0; k < SHW; k++) begin : g_stage
      localparam int D = 1 << k;
      assign stage_v[k+1] = amt[k] ? (stage_v[k] >> D) : stage_v[k];
      assign stage_s[k+1] = stage_s[k] | (amt[k] & (|stage_v[k][D-1:0]));
   end

   assign mag    = clamp ? '0 : stage_v[SHW][INT_W-1:0];
   assign sticky = clamp ? (|mant) : stage_s[SHW];

endmodule

// File: rtl/f2i_sat.sv
// Applies the sign-dependent limit, saturates, negates and sets the flags.
module f2i_sat #(
   parameter int INT_W = 32
) (
   input  logic             is_zero,
   input  logic             special,
   input  logic             exp_big,
   input  logic             sign,
   input  logic [INT_W-1:0] mag,
   input  logic             sticky,
   output logic [INT_W-1:0] res,
   output logic             inexact,
   output logic             invalid
);
   localparam logic [INT_W-1:0] POS_LIM = {1'b0, {(INT_W-1){1'b1}}};
   localparam logic [INT_W-1:0] NEG_LIM = {1'b1, {(INT_W-1){1'b0}}};

   logic mag_ovf;
   logic ovf;
   logic [INT_W-1:0] neg_mag;

   // Magnitude at or above 2^(N-1) overflows, except exactly 2^(N-1) when negative.
   assign mag_ovf = mag[INT_W-1] & (~sign | (|mag[INT_W-2:0]));
   assign ovf     = ~is_zero & (special | exp_big | mag_ovf);
   assign neg_mag = ~mag + 1'b1;

   always_comb begin
      if (is_zero)      res = '0;
      else if (ovf)     res = sign ? NEG_LIM : POS_LIM;
      else if (sign)    res = neg_mag;
      else              res = mag;
   end

   assign inexact = ~is_zero & ~ovf & sticky;
   assign invalid = ovf;

endmodule

// File: rtl/f2i_convert.sv
module f2i_convert
   import f2i_pkg::*;
#(
   parameter int INT_W  = 32,
   parameter int MANT_W = 53,
   parameter int EXP_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [2:0]        in_class,
   input  logic              in_sign,
   input  logic [EXP_W-1:0]  in_exp,
   input  logic [MANT_W-1:0] in_mant,
   output logic              out_valid,
   output logic [INT_W-1:0]  out_int,
   output logic              out_inexact,
   output logic              out_invalid
);
   localparam logic [INT_W-1:0] POS_LIM = {1'b0, {(INT_W-1){1'b1}}};
   localparam logic [INT_W-1:0] NEG_LIM = {1'b1, {(INT_W-1){1'b0}}};

   initial begin : g_param_chk
      assert (INT_W == 32 || INT_W == 64)
         else $fatal(1, "INT_W must be 32 or 64");
      assert (MANT_W >= 2)
         else $fatal(1, "MANT_W too small");
      assert ((MANT_W + INT_W) < (1 << (EXP_W - 1)))
         else $fatal(1, "EXP_W too narrow for the shift range");
   end

   // Stage A: alignment
   logic [INT_W-1:0] al_mag;
   logic             al_sticky;
   logic             al_big;

   f2i_align #(.INT_W(INT_W), .MANT_W(MANT_W), .EXP_W(EXP_W)) align_i (
      .mant    (in_mant),
      .exp_i   ($signed(in_exp)),
      .mag     (al_mag),
      .sticky  (al_sticky),
      .exp_big (al_big)
   );

   logic             a_valid, a_zero, a_special, a_big, a_sign, a_sticky;
   logic [INT_W-1:0] a_mag;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_valid   <= 1'b0;
         a_zero    <= 1'b1;
         a_special <= 1'b0;
         a_big     <= 1'b0;
         a_sign    <= 1'b0;
         a_sticky  <= 1'b0;
         a_mag     <= '0;
      end else begin
         a_valid   <= in_valid;
         a_zero    <= (in_class == CLS_ZERO);
         a_special <= f2i_is_special(in_class);
         a_big     <= al_big & (in_class == CLS_NORM);
         a_sign    <= in_sign;
         a_sticky  <= al_sticky;
         a_mag     <= al_mag;
      end
   end

   // Stage B: limit, negate, flags
   logic [INT_W-1:0] s_res;
   logic             s_inexact, s_invalid;

   f2i_sat #(.INT_W(INT_W)) sat_i (
      .is_zero (a_zero),
      .special (a_special),
      .exp_big (a_big),
      .sign    (a_sign),
      .mag     (a_mag),
      .sticky  (a_sticky),
      .res     (s_res),
      .inexact (s_inexact),
      .invalid (s_invalid)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_int     <= '0;
         out_inexact <= 1'b0;
         out_invalid <= 1'b0;
      end else begin
         out_valid   <= a_valid;
         out_int     <= s_res;
         out_inexact <= s_inexact;
         out_invalid <= s_invalid;
      end
   end

   // Input legality assumptions
   AST_CLASS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> (in_class <= 3'd4));                                     // R6
   AST_NORM_MSB: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_class == CLS_NORM) |-> in_mant[MANT_W-1]);           // R2

   // Behaviour at the ports
   AST_LATENCY_ON: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> ##1 out_valid);                                          // R9
   AST_LATENCY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ##1 !out_valid);                                        // R9
   AST_ZERO_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_class == CLS_ZERO) |=> ##1
         (out_int == '0 && !out_inexact && !out_invalid));                 // R1
   AST_SPECIAL_OVF: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && f2i_is_special(in_class)) |=> ##1 out_invalid);          // R6
   AST_EXP_OVF: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_class == CLS_NORM && $signed(in_exp) >= INT_W)
         |=> ##1 out_invalid);                                              // R4
   AST_NEG_EXP: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_class == CLS_NORM && $signed(in_exp) < 0)
         |=> ##1 (out_int == '0 && out_inexact && !out_invalid));           // R3
   AST_SAT_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_invalid) |->
         (out_int == POS_LIM || out_int == NEG_LIM));                       // R7
   AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !(out_invalid && out_inexact));                         // R7

endmodule

// File: tb/f2i_convert_tb.sv
module f2i_convert_tb_top;
   import f2i_pkg::*;

   localparam int INT_W  = 32;
   localparam int MANT_W = 53;
   localparam int EXP_W  = 12;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic [2:0]        in_class = '0;
   logic              in_sign = 1'b0;
   logic [EXP_W-1:0]  in_exp = '0;
   logic [MANT_W-1:0] in_mant = '0;
   logic              out_valid;
   logic [INT_W-1:0]  out_int;
   logic              out_inexact;
   logic              out_invalid;

   always #5 clk = ~clk;

   f2i_convert #(.INT_W(INT_W), .MANT_W(MANT_W), .EXP_W(EXP_W)) dut_i (
      .clk, .rst_n, .in_valid, .in_class, .in_sign, .in_exp, .in_mant,
      .out_valid, .out_int, .out_inexact, .out_invalid
   );

   typedef struct {
      logic             v;
      logic [INT_W-1:0] r;
      logic             ix;
      logic             iv;
      string            tag;
   } exp_t;

   exp_t p0, p1;
   int   checks = 0;
   int   errors = 0;
   bit   done = 1'b0;

   // Behavioural reference built from the requirements.
   function automatic exp_t model(input logic [2:0] c, input logic s, input int e,
                                  input logic [MANT_W-1:0] m, input string tag);
      exp_t        x;
      logic [255:0] big, mag, lim;
      logic        lost, ovf;
      int          sh;
      x.v = 1'b1; x.tag = tag;
      big = 256'(m); mag = '0; lost = 1'b0; ovf = 1'b0;
      if (c == 3'd0) begin
         x.r = '0; x.ix = 1'b0; x.iv = 1'b0; return x;
      end
      if (c != 3'd1) ovf = 1'b1;
      else if (e >= INT_W) ovf = 1'b1;
      else if (e < 0) begin
         mag = '0; lost = (m != '0);
      end else begin
         sh = MANT_W - 1 - e;
         if (sh >= 0) begin
            mag  = big >> sh;
            lost = ((big & ((256'd1 << sh) - 256'd1)) != '0);
         end else mag = big << (-sh);
      end
      lim = (256'd1 << (INT_W - 1)) + 256'(s);
      if (!ovf && mag >= lim) ovf = 1'b1;
      if (ovf) begin
         x.r  = s ? {1'b1, {(INT_W-1){1'b0}}} : {1'b0, {(INT_W-1){1'b1}}};
         x.ix = 1'b0; x.iv = 1'b1;
      end else begin
         x.r  = s ? (INT_W'(0) - mag[INT_W-1:0]) : mag[INT_W-1:0];
         x.ix = lost; x.iv = 1'b0;
      end
      return x;
   endfunction

   task automatic compare();
      checks++;
      if (out_valid !== p1.v) begin
         errors++;
         $display("FAIL R9 out_valid actual=%0b expected=%0b", out_valid, p1.v);
      end
      if (p1.v) begin
         checks++;
         if (out_int !== p1.r || out_inexact !== p1.ix || out_invalid !== p1.iv) begin
            errors++;
            $display("FAIL %s int/inexact/invalid actual=%h/%0b/%0b expected=%h/%0b/%0b",
                     p1.tag, out_int, out_inexact, out_invalid, p1.r, p1.ix, p1.iv);
         end
      end
   endtask

   task automatic step(input logic v, input logic [2:0] c, input logic s,
                       input int e, input logic [MANT_W-1:0] m, input string tag);
      @(negedge clk);
      compare();
      p1 = p0;
      if (v) p0 = model(c, s, e, m, tag);
      else begin p0.v = 1'b0; p0.tag = "R9"; end
      in_valid = v; in_class = c; in_sign = s; in_exp = EXP_W'(e); in_mant = m;
   endtask

   // Sends a fixed-point value v with fb fraction bits as a normal operand.
   task automatic put_val(input logic s, input logic [127:0] v, input int fb,
                          input string tag);
      int p;
      logic [MANT_W-1:0] m;
      p = 0;
      for (int i = 127; i >= 0; i--) if (v[i]) begin p = i; break; end
      if (p >= MANT_W - 1) m = MANT_W'(v >> (p - (MANT_W - 1)));
      else                 m = MANT_W'(v << (MANT_W - 1 - p));
      step(1'b1, 3'd1, s, p - fb, m, tag);
   endtask

   task automatic idle();
      step(1'b0, 3'd0, 1'b0, 0, '0, "R9");
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL R9 watchdog expired actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : stim
      logic [127:0] half;
      half = 128'd1 << (INT_W - 1);
      p0.v = 1'b0; p0.tag = "R9"; p1.v = 1'b0; p1.tag = "R9";
      // Reset state (R9)
      repeat (3) begin
         @(negedge clk);
         checks++;
         if (out_valid !== 1'b0 || out_int !== '0 || out_inexact !== 1'b0 || out_invalid !== 1'b0) begin
            errors++;
            $display("FAIL R9 reset outputs actual=%0b/%h/%0b/%0b expected=0/0/0/0",
                     out_valid, out_int, out_inexact, out_invalid);
         end
      end
      rst_n = 1'b1;
      idle();

      // R1: zero class ignores sign, exponent and mantissa
      step(1'b1, 3'd0, 1'b0, 5, {1'b1, {(MANT_W-1){1'b0}}}, "R1");
      step(1'b1, 3'd0, 1'b1, 40, {MANT_W{1'b1}}, "R1");
      // R2, R8: plain integers and truncation toward zero
      put_val(1'b0, 128'd5, 0, "R2");
      put_val(1'b1, 128'd5, 0, "R8");
      put_val(1'b1, 128'd7, 1, "R8");            // -3.5 -> -3 inexact
      put_val(1'b0, 128'd13, 2, "R2");           // 3.25 -> 3 inexact
      put_val(1'b0, 128'd1, 0, "R2");
      // R3: negative exponents
      put_val(1'b0, 128'd3, 2, "R3");            // 0.75
      put_val(1'b1, 128'd1, 20, "R3");
      step(1'b1, 3'd1, 1'b0, -200, {1'b1, {(MANT_W-1){1'b0}}}, "R3");
      // R5: boundaries
      put_val(1'b0, half - 1, 0, "R5");
      put_val(1'b1, half - 1, 0, "R5");
      put_val(1'b0, half, 0, "R5");
      put_val(1'b1, half, 0, "R5");
      put_val(1'b1, (half << 1) | 1, 1, "R5");   // -(2^31+0.5) -> -2^31 inexact
      put_val(1'b0, ((half - 1) << 2) | 3, 2, "R5");
      put_val(1'b1, half + 1, 0, "R5");
      // R4: large exponents
      put_val(1'b0, half << 1, 0, "R4");
      put_val(1'b1, half << 1, 0, "R4");
      step(1'b1, 3'd1, 1'b0, 400, {1'b1, {(MANT_W-1){1'b0}}}, "R4");
      // R6, R7: special classes
      step(1'b1, 3'd2, 1'b0, 0, '0, "R6");
      step(1'b1, 3'd2, 1'b1, 0, '0, "R6");
      step(1'b1, 3'd3, 1'b0, 0, {2'b11, {(MANT_W-2){1'b0}}}, "R6");
      step(1'b1, 3'd4, 1'b1, 0, {2'b10, {(MANT_W-2){1'b1}}}, "R7");
      idle(); idle();

      // Random mix with bubbles
      for (int n = 0; n < 3000; n++) begin
         logic [MANT_W-1:0] m;
         logic [2:0]        c;
         int                sel, e;
         m   = {$urandom(), $urandom()};
         m[MANT_W-1] = 1'b1;
         sel = $urandom_range(0, 15);
         c   = (sel < 11) ? 3'd1 : 3'(sel - 10);
         if (c > 3'd4) c = 3'd0;
         e   = $urandom_range(0, INT_W + 7) - 4;
         if ($urandom_range(0, 5) == 0) idle();
         else step(1'b1, c, 1'(($urandom() & 1)), e, m, (c == 3'd1) ? "R2" : "R6");
      end
      idle(); idle(); idle();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule